// File: doc/BRIEF.md
# Serial Port Control, Status and Interrupt Block

This block is the register front end of a serial port that runs in either asynchronous or clocked mode. A CPU reaches it over a plain register bus with address, write data, read data and read and write strobes. It holds the control bits that turn the transmitter and the receiver on and that let the receiver raise interrupts. It holds five status flags. It keeps the transmit and receive data registers. It turns event pulses from an outside shift engine into flag updates, two interrupt lines and a request to start sending. Bit timing, baud generation and the shift registers live in that engine.

Each status flag is cleared by a two-step handshake. Software must first read the flag as 1 in a status read, and then write 0 to that bit. A stray write can therefore never drop an event that software has not yet seen.

The edge toward the shift engine has no back-pressure in either direction. A completed receive word is a single-cycle pulse that the block must accept. If the receive data register is still full, the block records an overrun and does not stall the engine. On the transmit side, the block offers a word with a single-cycle start pulse. The engine returns a single-cycle pulse when it has taken that word. While the engine is busy, a pending start is held back.

Top module: `sio_ctl_irq`

Register map, with a data width of 8:
- Address 0 is control: bit 0 transmit on, bit 1 receive on, bit 2 receive interrupts on. Upper bits read 0.
- Address 1 is status: bit 0 transmit empty, bit 1 receive full, bit 2 framing error, bit 3 parity error, bit 4 overrun. Upper bits read 0.
- Address 2 is transmit data, which can be read and written.
- Address 3 is receive data, which is read only.

## Requirements
- R1: After reset, control reads 0x00, status reads 0x01 (only transmit empty is set), receive data reads 0x00, and both interrupts and the start pulse are low.
- R2: Control at address 0 keeps bits 0 to 2 (transmit on, receive on, receive interrupts on) and reads back with its upper bits 0. Transmit data at address 2 reads back what was written.
- R3: Writing 0 to a status bit clears that flag only if an earlier status read returned that flag as 1. Without such a read, the write leaves the flag set.
- R4: Writing 1 to any status bit has no effect on that flag, and it does not cancel an earlier read-as-1.
- R5: While transmit on is 0, transmit empty (status bit 0) reads 1 and a write of 0 cannot clear it.
- R6: With transmit on, tx_start is a one-cycle pulse. It comes in the cycle after transmit empty has become 0 while tx_busy is low, with tx_word equal to the transmit data register. Each word gives one pulse, and a busy engine delays it. A tx_taken pulse sets transmit empty again.
- R7: A rx_done pulse with receive on and receive full clear loads rx_word into receive data and sets receive full. With receive on at 0, receive and error events have no effect.
- R8: A rx_done pulse while receive full is set sets overrun (status bit 4) and leaves receive data unchanged.
- R9: An err_valid pulse with receive on sets framing error (bit 2) when err_frame is high and parity error (bit 3) when err_parity is high.
- R10: irq_rx_full equals receive full AND receive interrupts on. irq_rx_err equals (framing OR parity OR overrun) AND receive interrupts on.
- R11: A pending interrupt drops when its flags are cleared by the read-then-write-0 handshake, or when receive interrupts on is cleared.
- R12: Clearing receive on leaves receive full, framing, parity and overrun unchanged.
- R13: When an event sets a flag in the same cycle as a valid clearing write to it, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a status read arms clearing |
| bus_rdata | output | DATA_W | Read data, combinational from address |
| rx_done | input | 1 | Engine finished a received word |
| rx_word | input | DATA_W | The received word |
| err_valid | input | 1 | Engine reports a receive error |
| err_frame | input | 1 | Error is a framing error |
| err_parity | input | 1 | Error is a parity error |
| tx_taken | input | 1 | Engine took the transmit word |
| tx_busy | input | 1 | Engine is shifting |
| tx_start | output | 1 | One-cycle request to start sending |
| tx_word | output | DATA_W | Word to send |
| irq_rx_full | output | 1 | Receive-full interrupt |
| irq_rx_err | output | 1 | Receive-error interrupt |

## Verification
The bench tries to clear a flag with a write of 0 that no read has armed. A design without the arming step would drop the flag, and the next status read would show the difference. It writes 1s between the arming read and the clearing write, to catch a design that clears on any write or that loses its arm. It sends a second receive word into a full register: a wrong design would overwrite the data or skip overrun. It clears a flag in the same cycle as a new error event: a clear-wins design would lose the event. It also holds the engine busy across a start request, which would expose a lost or doubled start pulse, and it turns transmit off with data pending to confirm that transmit empty is forced to 1.

// File: rtl/sio_pkg.sv
package sio_pkg;

  // status flag positions
  localparam int ST_TXE  = 0;
  localparam int ST_FULL = 1;
  localparam int ST_FRM  = 2;
  localparam int ST_PAR  = 3;
  localparam int ST_OVR  = 4;
  localparam int STAT_W  = 5;
  localparam int CTL_W   = 3;

  localparam logic [STAT_W-1:0] STAT_RST = STAT_W'(1) << ST_TXE;

  typedef struct packed {
    logic irq_on;
    logic rx_on;
    logic tx_on;
  } ctl_t;

  typedef struct packed {
    logic ovr;
    logic par;
    logic frm;
    logic full;
    logic txe;
  } status_t;

  typedef enum logic [1:0] {
    REG_CTL  = 2'd0,
    REG_STAT = 2'd1,
    REG_TXD  = 2'd2,
    REG_RXD  = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/sio_regfile.sv
module sio_regfile
  import sio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctl,
  input  logic              wr_txd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rx_capture,
  input  logic [DATA_W-1:0] rx_word,
  output ctl_t              ctl_q,
  output logic [DATA_W-1:0] txd_q,
  output logic [DATA_W-1:0] rxd_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      txd_q <= '0;
      rxd_q <= '0;
    end else begin
      if (wr_ctl)     ctl_q <= ctl_t'(wdata[CTL_W-1:0]);
      if (wr_txd)     txd_q <= wdata;
      if (rx_capture) rxd_q <= rx_word;
    end
  end

endmodule

// File: rtl/sio_flags.sv
module sio_flags
  import sio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_on,
  input  logic              rd_stat,
  input  logic              wr_stat,
  input  logic [STAT_W-1:0] wr_bits,
  input  logic              rx_load,
  input  logic              frm_evt,
  input  logic              par_evt,
  input  logic              tx_taken,
  output status_t           view,
  output logic              rx_accept
);

  logic [STAT_W-1:0] flag_q, arm_q, set_v, force_v, clr_v, view_v;

  always_comb begin
    force_v         = '0;
    force_v[ST_TXE] = ~tx_on;
    set_v           = '0;
    set_v[ST_TXE]   = tx_taken;
    set_v[ST_FULL]  = rx_load;
    set_v[ST_FRM]   = frm_evt;
    set_v[ST_PAR]   = par_evt;
    set_v[ST_OVR]   = rx_load & flag_q[ST_FULL];
  end

  assign view_v    = flag_q | force_v;
  assign view      = status_t'(view_v);
  assign rx_accept = rx_load & ~flag_q[ST_FULL];

  // clearing needs a prior read-as-1 and a written 0
  for (genvar i = 0; i < STAT_W; i++) begin : g_clr
    assign clr_v[i] = wr_stat & ~wr_bits[i] & arm_q[i] & ~force_v[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= STAT_RST;
      arm_q  <= '0;
    end else begin
      for (int i = 0; i < STAT_W; i++) begin
        if (force_v[i] || set_v[i]) flag_q[i] <= 1'b1;
        else if (clr_v[i])          flag_q[i] <= 1'b0;
        if (clr_v[i])                    arm_q[i] <= 1'b0;
        else if (rd_stat && view_v[i])   arm_q[i] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sio_tx_launch.sv
module sio_tx_launch (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_on,
  input  logic tx_empty,
  input  logic tx_busy,
  output logic tx_start
);

  logic launched_q, fire;

  assign fire = tx_on & ~tx_empty & ~launched_q & ~tx_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_start   <= 1'b0;
      launched_q <= 1'b0;
    end else begin
      tx_start <= fire;
      if (tx_empty)  launched_q <= 1'b0;
      else if (fire) launched_q <= 1'b1;
    end
  end

endmodule

// File: rtl/sio_irq.sv
module sio_irq
  import sio_pkg::*;
(
  input  logic    irq_on,
  input  status_t flags,
  output logic    irq_full,
  output logic    irq_err
);

  assign irq_full = irq_on & flags.full;
  assign irq_err  = irq_on & (flags.frm | flags.par | flags.ovr);

endmodule

// File: rtl/sio_ctl_irq.sv
module sio_ctl_irq
  import sio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_word,
  input  logic              err_valid,
  input  logic              err_frame,
  input  logic              err_parity,
  input  logic              tx_taken,
  input  logic              tx_busy,
  output logic              tx_start,
  output logic [DATA_W-1:0] tx_word,
  output logic              irq_rx_full,
  output logic              irq_rx_err
);

  ctl_t              ctl_q;
  status_t           stat_view;
  logic [DATA_W-1:0] txd_q, rxd_q;
  logic              sel_ctl, sel_stat, sel_txd, sel_rxd;
  logic              rx_accept;

  assign sel_ctl  = (bus_addr == ADDR_W'(REG_CTL));
  assign sel_stat = (bus_addr == ADDR_W'(REG_STAT));
  assign sel_txd  = (bus_addr == ADDR_W'(REG_TXD));
  assign sel_rxd  = (bus_addr == ADDR_W'(REG_RXD));

  sio_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ctl     (bus_wr & sel_ctl),
    .wr_txd     (bus_wr & sel_txd),
    .wdata      (bus_wdata),
    .rx_capture (rx_accept),
    .rx_word    (rx_word),
    .ctl_q      (ctl_q),
    .txd_q      (txd_q),
    .rxd_q      (rxd_q)
  );

  sio_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_on     (ctl_q.tx_on),
    .rd_stat   (bus_rd & sel_stat),
    .wr_stat   (bus_wr & sel_stat),
    .wr_bits   (bus_wdata[STAT_W-1:0]),
    .rx_load   (rx_done & ctl_q.rx_on),
    .frm_evt   (err_valid & err_frame & ctl_q.rx_on),
    .par_evt   (err_valid & err_parity & ctl_q.rx_on),
    .tx_taken  (tx_taken),
    .view      (stat_view),
    .rx_accept (rx_accept)
  );

  sio_tx_launch u_launch (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_on    (ctl_q.tx_on),
    .tx_empty (stat_view.txe),
    .tx_busy  (tx_busy),
    .tx_start (tx_start)
  );

  sio_irq u_irq (
    .irq_on   (ctl_q.irq_on),
    .flags    (stat_view),
    .irq_full (irq_rx_full),
    .irq_err  (irq_rx_err)
  );

  assign tx_word = txd_q;

  always_comb begin
    bus_rdata = '0;
    if (sel_ctl)  bus_rdata = DATA_W'(ctl_q);
    if (sel_stat) bus_rdata = DATA_W'(stat_view);
    if (sel_txd)  bus_rdata = txd_q;
    if (sel_rxd)  bus_rdata = rxd_q;
  end

endmodule

// File: rtl/sio_ctl_irq_chk.sv
module sio_ctl_irq_chk
  import sio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input ctl_t              ctl,
  input status_t           flags,
  input logic [DATA_W-1:0] rxd,
  input logic              rx_done,
  input logic              tx_busy,
  input logic              tx_start,
  input logic              irq_rx_full,
  input logic              irq_rx_err,
  input logic              stat_wr,
  input logic              full_wbit
);

  // R5
  txe_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.tx_on |-> flags.txe);

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.irq_on |-> (!irq_rx_full && !irq_rx_err));

  // R6
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);

  // R6
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> $past(ctl.tx_on && !tx_busy && !flags.txe));

  // R8
  overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && ctl.rx_on && flags.full) |=> (flags.ovr && $stable(rxd)));

  // R3
  full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags.full) |-> $past(stat_wr && !full_wbit));

endmodule

bind sio_ctl_irq sio_ctl_irq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctl         (ctl_q),
  .flags       (stat_view),
  .rxd         (rxd_q),
  .rx_done     (rx_done),
  .tx_busy     (tx_busy),
  .tx_start    (tx_start),
  .irq_rx_full (irq_rx_full),
  .irq_rx_err  (irq_rx_err),
  .stat_wr     (bus_wr & sel_stat),
  .full_wbit   (bus_wdata[ST_FULL])
);

// File: tb/test_sio_ctl_irq.sv
module test_sio_ctl_irq;
  localparam int DW = 8;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic          rx_done = 1'b0;
  logic [DW-1:0] rx_word = '0;
  logic          err_valid = 1'b0, err_frame = 1'b0, err_parity = 1'b0;
  logic          tx_taken = 1'b0, tx_busy = 1'b0;
  logic          tx_start;
  logic [DW-1:0] tx_word;
  logic          irq_rx_full, irq_rx_err;

  int checks = 0;
  int errors = 0;
  int starts = 0;
  int base;

  int    exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  sio_ctl_irq #(.DATA_W(DW), .ADDR_W(AW)) i_sio_ctl_irq (.*);

  task automatic expect_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compare read data at the negedge of every read cycle
  always @(negedge clk) begin
    if (tx_start) starts++;
    if (bus_rd) begin
      if (exp_q.size() == 0) expect_eq("scoreboard empty", 1, 0);
      else expect_eq(tag_q.pop_front(), int'(bus_rdata), exp_q.pop_front());
    end
  end

  task automatic cpu_write(input int a, input int d);
    @(posedge clk); #1;
    bus_addr = AW'(a); bus_wdata = DW'(d); bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic cpu_read(input int a, input int exp, input string tag);
    @(posedge clk); #1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_addr = AW'(a); bus_rd = 1'b1;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic pulse_rx(input int d);
    @(posedge clk); #1;
    rx_done = 1'b1; rx_word = DW'(d);
    @(posedge clk); #1;
    rx_done = 1'b0;
  endtask

  task automatic pulse_err(input logic f, input logic p);
    @(posedge clk); #1;
    err_valid = 1'b1; err_frame = f; err_parity = p;
    @(posedge clk); #1;
    err_valid = 1'b0; err_frame = 1'b0; err_parity = 1'b0;
  endtask

  task automatic check_irq(input int full, input int err, input string tag);
    @(negedge clk);
    expect_eq({tag, " irq_rx_full"}, int'(irq_rx_full), full);
    expect_eq({tag, " irq_rx_err"}, int'(irq_rx_err), err);
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    cpu_read(0, 8'h00, "R1 control");
    cpu_read(1, 8'h01, "R1 status");
    cpu_read(3, 8'h00, "R1 rx data");
    check_irq(0, 0, "R1");
    expect_eq("R1 tx_start", int'(tx_start), 0);

    // R2 map and readback
    cpu_write(0, 8'h07);
    cpu_read(0, 8'h07, "R2 control");
    cpu_write(0, 8'hF8);
    cpu_read(0, 8'h00, "R2 control upper bits");
    cpu_write(2, 8'hA5);
    cpu_read(2, 8'hA5, "R2 tx data");
    cpu_write(0, 8'h00);

    // R5 transmit empty forced while transmit off
    cpu_read(1, 8'h01, "R5 status arm");
    cpu_write(1, 8'h00);
    cpu_read(1, 8'h01, "R5 txe not cleared");

    // R7 receive off ignores events
    pulse_rx(8'h3C);
    pulse_err(1'b1, 1'b1);
    cpu_read(1, 8'h01, "R7 ignored status");
    cpu_read(3, 8'h00, "R7 ignored data");

    // R7 normal receive
    cpu_write(0, 8'h06);
    pulse_rx(8'h5A);
    cpu_read(3, 8'h5A, "R7 rx data");
    check_irq(1, 0, "R10 full");

    // R3 write 0 without read does not clear; R4 write 1 no effect
    cpu_write(1, 8'hFD);
    cpu_read(1, 8'h03, "R3 unarmed write");
    cpu_write(1, 8'hFF);
    cpu_read(1, 8'h03, "R4 write ones");
    cpu_write(1, 8'hFD);
    cpu_read(1, 8'h01, "R3 armed clear");
    check_irq(0, 0, "R11 flag cleared");

    // R8 overrun
    pulse_rx(8'h11);
    pulse_rx(8'h22);
    cpu_read(1, 8'h13, "R8 overrun status");
    cpu_read(3, 8'h11, "R8 data kept");
    check_irq(1, 1, "R10 overrun");

    // R11 mask by enable; R12 flags kept with receive off
    cpu_write(0, 8'h02);
    check_irq(0, 0, "R11 enable cleared");
    cpu_write(0, 8'h00);
    cpu_read(1, 8'h13, "R12 flags kept");
    cpu_write(0, 8'h06);
    check_irq(1, 1, "R10 re-enabled");
    cpu_write(1, 8'hEF);
    cpu_read(1, 8'h03, "R3 clear overrun");
    check_irq(1, 0, "R11 err dropped");
    cpu_write(1, 8'hFD);
    cpu_read(1, 8'h01, "R3 clear full");

    // R9 error flags
    pulse_err(1'b1, 1'b0);
    cpu_read(1, 8'h05, "R9 framing");
    check_irq(0, 1, "R10 framing");
    pulse_err(1'b0, 1'b1);
    cpu_read(1, 8'h0D, "R9 parity");

    // R13 set wins over clear in the same cycle
    @(posedge clk); #1;
    bus_addr = AW'(1); bus_wdata = 8'hFB; bus_wr = 1'b1;
    err_valid = 1'b1; err_frame = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0; err_valid = 1'b0; err_frame = 1'b0;
    cpu_read(1, 8'h0D, "R13 set wins");
    cpu_write(1, 8'hF7);
    cpu_read(1, 8'h05, "R3 clear parity");
    cpu_write(1, 8'hFB);
    cpu_read(1, 8'h01, "R3 clear framing");
    check_irq(0, 0, "R11 all clear");

    // R6 transmit start
    cpu_write(0, 8'h01);
    cpu_read(1, 8'h01, "R6 arm txe");
    cpu_write(2, 8'h96);
    cpu_write(1, 8'hFE);
    @(negedge clk);
    expect_eq("R6 no start yet", int'(tx_start), 0);
    @(negedge clk);
    expect_eq("R6 start pulse", int'(tx_start), 1);
    expect_eq("R6 tx word", int'(tx_word), 8'h96);
    @(negedge clk);
    expect_eq("R6 single cycle", int'(tx_start), 0);
    cpu_read(1, 8'h00, "R6 txe low");
    @(posedge clk); #1 tx_taken = 1'b1;
    @(posedge clk); #1 tx_taken = 1'b0;
    cpu_read(1, 8'h01, "R6 taken sets txe");

    // R6 busy engine delays start
    tx_busy = 1'b1;
    cpu_read(1, 8'h01, "R6 arm busy");
    base = starts;
    cpu_write(1, 8'hFE);
    repeat (4) @(negedge clk);
    expect_eq("R6 held while busy", starts - base, 0);
    @(posedge clk); #1 tx_busy = 1'b0;
    repeat (4) @(negedge clk);
    expect_eq("R6 one start after busy", starts - base, 1);

    // R5 disabling transmit forces empty
    cpu_write(0, 8'h00);
    cpu_read(1, 8'h01, "R5 forced on disable");
    cpu_write(0, 8'h01);
    cpu_read(1, 8'h01, "R5 stays set after enable");
    repeat (3) @(negedge clk);
    expect_eq("R6 no spurious start", starts - base, 1);

    summary();
  end

endmodule